// File: doc/BRIEF.md
# Accumulator-Based 8-Bit Microcoded Processor

This block is a very small processor core. A single 8-bit bus, built as a multiplexer with no tri-state drivers, links every register. Those registers are a 4-bit program counter, a 4-bit memory address register, a 16-byte store that holds both program and data, an instruction register, accumulator A, operand register B, an add/subtract unit with carry and zero flags, and an output register. A sequencer state machine turns each opcode into 16 control lines over five fixed micro-steps.

The program and its data are supplied as a parameter image at elaboration. After reset is released, execution starts at address 0. Results leave the block through the output register, with a one-cycle strobe for each write. A halt instruction freezes the core until the next reset.

Sequencer states:
- `ST_FETCH_ADDR`: the program counter is moved to the address register.
- `ST_FETCH_INSN`: the addressed byte is loaded into the instruction register and the program counter is incremented.
- `ST_EXEC1`, `ST_EXEC2`, `ST_EXEC3`: the steps that depend on the opcode.
- `ST_HALT`: the core is stopped.

Transitions:
- `ST_FETCH_ADDR` always moves to `ST_FETCH_INSN`.
- `ST_FETCH_INSN` always moves to `ST_EXEC1`.
- `ST_EXEC1` moves to `ST_HALT` on a halt instruction, and to `ST_EXEC2` otherwise.
- `ST_EXEC2` always moves to `ST_EXEC3`.
- `ST_EXEC3` always moves back to `ST_FETCH_ADDR`.
- `ST_HALT` stays in `ST_HALT` until reset.

Reset, which is synchronous and active high, returns the sequencer to `ST_FETCH_ADDR`.

Top module: `acc_cpu`

## Requirements
- R1: While `rst` is high, `out_data` is 0, `out_valid` is 0 and `halted` is 0. After release, execution starts at address 0. Reset does not reload the memory.
- R2: Instruction byte and timing.
  - Memory byte i is taken from bits [8i+7:8i] of `INIT_IMAGE`.
  - In each instruction byte, bits [7:4] are the opcode and bits [3:0] are the operand.
  - Opcodes: NOP=0, LDA=1, ADD=2, SUB=3, STA=4, LDI=5, JMP=6, JC=7, JZ=8, OUT=14, HLT=15.
  - Every instruction takes exactly 5 clock cycles. The k-th executed instruction (counting from 0) begins on clock edge 5k+1 after reset release.
- R3: LDA loads A from memory at the operand address. ADD and SUB replace A with A+mem or A−mem, modulo 256.
- R4: Flags.
  - On ADD, carry is the carry-out of the sum.
  - On SUB, carry is the carry-out of A + ~B + 1, so carry=1 means no borrow.
  - Zero is set when the 8-bit result is 0.
  - The flags change only on ADD and SUB.
- R5: JMP loads the program counter with the operand. JC does so only when carry is 1, and JZ only when zero is 1. A jump that is not taken falls through to the next byte.
- R6: STA writes A to memory at the operand address. LDI loads the 4-bit operand, zero-extended, into A.
- R7: OUT copies A to `out_data`. `out_valid` is high for exactly one cycle, the cycle after clock edge 5k+3 of that instruction.
- R8: HLT raises `halted` after clock edge 5k+3. From then on, no register or output changes and no strobe appears until reset. A reset restarts the program from address 0.
- R9: The program counter wraps from 15 to 0. Opcodes 9 through 13 execute as NOP.
- R10: In every micro-step at most one source drives the shared bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| out_data | output | 8 | Output register value |
| out_valid | output | 1 | One-cycle strobe when OUT writes the output register |
| halted | output | 1 | High once HLT has executed, until reset |

## Verification
Two cases are hardest to reach from the ports, because they leave no direct trace on an output.

The first is proving that flags persist across an instruction that is not arithmetic. One program sets zero with a SUB, then executes LDI, then a JZ that skips over a HLT. A fall-through would stop the core early and lose the following OUT.

The second is the wrap of the program counter from 15 to 0. Another program jumps to an unassigned opcode at address 15. It must then run the whole sequence again and produce the same OUT values at exactly 60-cycle spacing.

Timing is checked by recording the clock edge of every strobe and of the halt.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int OPC_W = 4;

    typedef enum logic [OPC_W-1:0] {
        OP_NOP = 4'h0,
        OP_LDA = 4'h1,
        OP_ADD = 4'h2,
        OP_SUB = 4'h3,
        OP_STA = 4'h4,
        OP_LDI = 4'h5,
        OP_JMP = 4'h6,
        OP_JC  = 4'h7,
        OP_JZ  = 4'h8,
        OP_OUT = 4'hE,
        OP_HLT = 4'hF
    } opcode_e;

    typedef enum logic [2:0] {
        ST_FETCH_ADDR,
        ST_FETCH_INSN,
        ST_EXEC1,
        ST_EXEC2,
        ST_EXEC3,
        ST_HALT
    } step_e;

    // Sixteen control lines issued by the sequencer each micro-step
    typedef struct packed {
        logic pc_out;
        logic pc_inc;
        logic pc_load;
        logic mar_in;
        logic ram_out;
        logic ram_in;
        logic ir_out;
        logic ir_in;
        logic a_out;
        logic a_in;
        logic b_in;
        logic alu_out;
        logic alu_sub;
        logic flags_in;
        logic out_in;
        logic hlt;
    } ctl_t;

endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    output logic [DATA_W-1:0] result,
    output logic              carry,
    output logic              zero
);

    logic [DATA_W-1:0] b_eff;
    logic [DATA_W:0]   wide;

    always_comb begin
        b_eff  = sub ? ~b : b;
        wide   = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub};
        result = wide[DATA_W-1:0];
        carry  = wide[DATA_W];
        zero   = (wide[DATA_W-1:0] == '0);
    end

endmodule

// File: rtl/acc_cpu_ram.sv
module acc_cpu_ram #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4,
    parameter logic [(2**ADDR_W)*DATA_W-1:0] INIT = '0
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 2**ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            mem[i] = INIT[i*DATA_W +: DATA_W];
        end
    end

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/acc_cpu_seq.sv
module acc_cpu_seq
    import acc_cpu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OPC_W-1:0] opcode,
    input  logic             carry,
    input  logic             zero,
    output ctl_t             ctl,
    output logic             halted
);

    step_e state;
    step_e state_nx;

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FETCH_ADDR: state_nx = ST_FETCH_INSN;
            ST_FETCH_INSN: state_nx = ST_EXEC1;
            ST_EXEC1:      state_nx = (opcode == OP_HLT) ? ST_HALT : ST_EXEC2;
            ST_EXEC2:      state_nx = ST_EXEC3;
            ST_EXEC3:      state_nx = ST_FETCH_ADDR;
            ST_HALT:       state_nx = ST_HALT;
            default:       state_nx = ST_FETCH_ADDR;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_FETCH_ADDR;
        end else begin
            state <= state_nx;
        end
    end

    // Output decode: control lines per micro-step
    always_comb begin
        ctl    = '0;
        halted = (state == ST_HALT);
        unique case (state)
            ST_FETCH_ADDR: begin
                ctl.pc_out = 1'b1;
                ctl.mar_in = 1'b1;
            end
            ST_FETCH_INSN: begin
                ctl.ram_out = 1'b1;
                ctl.ir_in   = 1'b1;
                ctl.pc_inc  = 1'b1;
            end
            ST_EXEC1: begin
                case (opcode)
                    OP_LDA, OP_ADD, OP_SUB, OP_STA: begin
                        ctl.ir_out = 1'b1;
                        ctl.mar_in = 1'b1;
                    end
                    OP_LDI: begin
                        ctl.ir_out = 1'b1;
                        ctl.a_in   = 1'b1;
                    end
                    OP_JMP: begin
                        ctl.ir_out  = 1'b1;
                        ctl.pc_load = 1'b1;
                    end
                    OP_JC: begin
                        ctl.ir_out  = carry;
                        ctl.pc_load = carry;
                    end
                    OP_JZ: begin
                        ctl.ir_out  = zero;
                        ctl.pc_load = zero;
                    end
                    OP_OUT: begin
                        ctl.a_out  = 1'b1;
                        ctl.out_in = 1'b1;
                    end
                    OP_HLT: ctl.hlt = 1'b1;
                    default: ;
                endcase
            end
            ST_EXEC2: begin
                case (opcode)
                    OP_LDA: begin
                        ctl.ram_out = 1'b1;
                        ctl.a_in    = 1'b1;
                    end
                    OP_ADD, OP_SUB: begin
                        ctl.ram_out = 1'b1;
                        ctl.b_in    = 1'b1;
                    end
                    OP_STA: begin
                        ctl.a_out  = 1'b1;
                        ctl.ram_in = 1'b1;
                    end
                    default: ;
                endcase
            end
            ST_EXEC3: begin
                if (opcode == OP_ADD || opcode == OP_SUB) begin
                    ctl.alu_out  = 1'b1;
                    ctl.alu_sub  = (opcode == OP_SUB);
                    ctl.a_in     = 1'b1;
                    ctl.flags_in = 1'b1;
                end
            end
            ST_HALT: ;
            default: ;
        endcase
    end

    // R8: once halted, the sequencer never leaves the halt state
    a_r8_halt_sticky: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HALT) |=> (state == ST_HALT));

    // R2: the last execute step always hands over to a new fetch
    a_r2_five_steps: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EXEC3) |=> (state == ST_FETCH_ADDR));

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4,
    parameter logic [(2**ADDR_W)*DATA_W-1:0] INIT_IMAGE = '0
) (
    input  logic              clk,
    input  logic              rst,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    output logic              halted
);

    localparam int PAD_W = DATA_W - ADDR_W;

    ctl_t              ctl;
    logic [ADDR_W-1:0] pc;
    logic [ADDR_W-1:0] mar;
    logic [DATA_W-1:0] ir;
    logic [DATA_W-1:0] a_reg;
    logic [DATA_W-1:0] b_reg;
    logic              carry_f;
    logic              zero_f;
    logic [DATA_W-1:0] bus;
    logic [DATA_W-1:0] ram_rd;
    logic [DATA_W-1:0] alu_res;
    logic              alu_c;
    logic              alu_z;

    acc_cpu_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .opcode (ir[DATA_W-1 -: OPC_W]),
        .carry  (carry_f),
        .zero   (zero_f),
        .ctl    (ctl),
        .halted (halted)
    );

    acc_cpu_ram #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .INIT   (INIT_IMAGE)
    ) u_ram (
        .clk   (clk),
        .addr  (mar),
        .we    (ctl.ram_in),
        .wdata (bus),
        .rdata (ram_rd)
    );

    acc_cpu_alu #(
        .DATA_W (DATA_W)
    ) u_alu (
        .a      (a_reg),
        .b      (b_reg),
        .sub    (ctl.alu_sub),
        .result (alu_res),
        .carry  (alu_c),
        .zero   (alu_z)
    );

    // Shared bus multiplexer
    always_comb begin
        if (ctl.pc_out)       bus = {{PAD_W{1'b0}}, pc};
        else if (ctl.ram_out) bus = ram_rd;
        else if (ctl.ir_out)  bus = {{PAD_W{1'b0}}, ir[ADDR_W-1:0]};
        else if (ctl.a_out)   bus = a_reg;
        else if (ctl.alu_out) bus = alu_res;
        else                  bus = '0;
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            pc        <= '0;
            mar       <= '0;
            ir        <= '0;
            a_reg     <= '0;
            b_reg     <= '0;
            carry_f   <= 1'b0;
            zero_f    <= 1'b0;
            out_data  <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= ctl.out_in;
            if (ctl.pc_load)      pc <= bus[ADDR_W-1:0];
            else if (ctl.pc_inc)  pc <= pc + 1'b1;
            if (ctl.mar_in)       mar <= bus[ADDR_W-1:0];
            if (ctl.ir_in)        ir <= bus;
            if (ctl.a_in)         a_reg <= bus;
            if (ctl.b_in)         b_reg <= bus;
            if (ctl.out_in)       out_data <= bus;
            if (ctl.flags_in) begin
                carry_f <= alu_c;
                zero_f  <= alu_z;
            end
        end
    end

    // R10: at most one bus source per micro-step
    a_r10_one_driver: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ctl.pc_out, ctl.ram_out, ctl.ir_out, ctl.a_out, ctl.alu_out}));

    // R9: program counter wraps from its top value to zero
    a_r9_pc_wrap: assert property (@(posedge clk) disable iff (rst)
        (ctl.pc_inc && !ctl.pc_load && pc == '1) |=> (pc == '0));

    // R7: output strobe lasts one cycle
    a_r7_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R8: nothing changes while halted
    a_r8_frozen: assert property (@(posedge clk) disable iff (rst)
        halted |=> ($stable(pc) && $stable(a_reg) && $stable(out_data) && !out_valid));

    // R4: flags hold unless an arithmetic step writes them
    a_r4_flags_hold: assert property (@(posedge clk) disable iff (rst)
        !ctl.flags_in |=> ($stable(carry_f) && $stable(zero_f)));

endmodule

// File: tb/acc_cpu_test.sv
module acc_cpu_test;

    // Program 1: LDA/ADD/SUB/STA/LDI/OUT/HLT
    localparam logic [127:0] IMG_ARITH  = 128'h1C386400_00F0E01C_E0574CE0_3DE02F1E;
    // Program 2: jumps, unassigned opcodes, PC wrap (loops forever)
    localparam logic [127:0] IMG_BRANCH = 128'hD5F1016F_E09A8373_3DE0F086_F0742E5F;
    // Program 3: flag persistence and JC not taken
    localparam logic [127:0] IMG_FLAGS  = 128'h05020000_0000F0E0_792EE0F0_85533F55;

    logic clk = 1'b0;
    logic rst = 1'b1;
    int   cyc;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    logic [7:0] d1, d2, d3;
    logic       v1, v2, v3, h1, h2, h3;

    always #5 clk = ~clk;

    acc_cpu #(.INIT_IMAGE(IMG_ARITH)) uut (
        .clk(clk), .rst(rst), .out_data(d1), .out_valid(v1), .halted(h1));
    acc_cpu #(.INIT_IMAGE(IMG_BRANCH)) uut_br (
        .clk(clk), .rst(rst), .out_data(d2), .out_valid(v2), .halted(h2));
    acc_cpu #(.INIT_IMAGE(IMG_FLAGS)) uut_fl (
        .clk(clk), .rst(rst), .out_data(d3), .out_valid(v3), .halted(h3));

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    // Strobe and halt logs, sampled at the falling edge
    int         n1, n2, n3, hc1, hc2, hc3;
    logic [7:0] val1 [8];
    logic [7:0] val2 [8];
    logic [7:0] val3 [8];
    int         cy1 [8];
    int         cy2 [8];
    int         cy3 [8];

    always @(negedge clk) begin
        if (rst) begin
            n1 = 0; n2 = 0; n3 = 0; hc1 = 0; hc2 = 0; hc3 = 0;
        end else begin
            if (v1) begin if (n1 < 8) begin val1[n1] = d1; cy1[n1] = cyc; end n1++; end
            if (v2) begin if (n2 < 8) begin val2[n2] = d2; cy2[n2] = cyc; end n2++; end
            if (v3) begin if (n3 < 8) begin val3[n3] = d3; cy3[n3] = cyc; end n3++; end
            if (h1 && hc1 == 0) hc1 = cyc;
            if (h2 && hc2 == 0) hc2 = cyc;
            if (h3 && hc3 == 0) hc3 = cyc;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic apply_reset();
        rst = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic release_and_run(input int edges);
        rst = 1'b0;
        while (cyc < edges) @(negedge clk);
    endtask

    task automatic test_reset_state();
        apply_reset();
        chk("R1 out_data uut", d1, 0);
        chk("R1 out_valid uut", v1, 0);
        chk("R1 halted uut", h1, 0);
        chk("R1 out_data uut_br", d2, 0);
        chk("R1 halted uut_fl", h3, 0);
    endtask

    task automatic test_arith();
        chk("R7 strobe count uut", n1, 4);
        chk("R3 LDA+ADD value", val1[0], 84);
        chk("R2 first OUT edge", cy1[0], 13);
        chk("R3 SUB wrap value", val1[1], 240);
        chk("R7 second OUT edge", cy1[1], 23);
        chk("R6 LDI zero-extend", val1[2], 7);
        chk("R6 STA then LDA R10", val1[3], 240);
        chk("R2 fourth OUT edge", cy1[3], 48);
    endtask

    task automatic test_halt();
        chk("R8 halt edge uut", hc1, 53);
        chk("R8 halted held", h1, 1);
        chk("R8 out frozen", d1, 240);
        chk("R8 halt edge uut_fl", hc3, 43);
    endtask

    task automatic test_branch();
        chk("R4 ADD carry+zero then R5 JC/JZ taken", val2[0], 0);
        chk("R5 taken jump edge", cy2[0], 23);
        chk("R4 SUB borrow, R5 not taken, R9 NOP", val2[1], 255);
        chk("R9 unassigned NOP edge", cy2[1], 48);
        chk("R9 PC wrap repeat value", val2[2], 0);
        chk("R9 PC wrap edge", cy2[2], 83);
        chk("R9 second loop value", val2[3], 255);
        chk("R9 no halt", h2, 0);
    endtask

    task automatic test_flags();
        chk("R4 flags persist over LDI", n3, 2);
        chk("R4 flag persist OUT value", val3[0], 3);
        chk("R4 flag persist OUT edge", cy3[0], 23);
        chk("R5 JC not taken after ADD", val3[1], 5);
        chk("R5 JC not taken edge", cy3[1], 38);
    endtask

    task automatic test_rerun();
        apply_reset();
        chk("R1 reset clears halted", h1, 0);
        chk("R1 reset clears out_data", d1, 0);
        release_and_run(60);
        chk("R8 restart first value", val1[0], 84);
        chk("R8 restart first edge", cy1[0], 13);
        chk("R8 restart halt edge", hc1, 53);
        chk("R1 no memory reload, rerun value", val1[3], 240);
    endtask

    initial begin
        test_reset_state();
        release_and_run(150);
        test_arith();
        test_halt();
        test_branch();
        test_flags();
        test_rerun();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule